// File: doc/BRIEF.md
# Tail-Pointer Descriptor Ring Fetcher

This block is the fetch front end of one DMA channel. Software places fixed-size descriptors of four 32-bit words (16 bytes) in a circular region of memory. It then tells the block where the region starts, how many entries it holds, and how far it has filled it. The fill level is a tail address that points one entry past the last descriptor handed over. Every entry from the current position up to the one just before the tail belongs to the engine. The same block serves a transmit ring or a receive ring.

The engine reads each owned descriptor with four word reads on an in-order request/response memory port. It presents the assembled 128-bit descriptor and its address on a valid/ready output. The current pointer moves on by 16 bytes only after the consumer has taken the descriptor. After the last entry it goes back to the start address. When the current pointer reaches the tail, the engine parks in a suspended state, raises a one-cycle suspend pulse and holds a suspended level. A later tail write that opens up work starts it again.

The controller has four states:
- `ST_IDLE`: the state after reset.
- `ST_FETCH`: the word reads are being issued and collected.
- `ST_OFFER`: the descriptor is presented.
- `ST_SUSP`: the ring is drained.

It has these transitions:
- IDLE→FETCH and SUSP→FETCH: on a tail write that leaves the current pointer unequal to the tail.
- FETCH→OFFER: on the fourth read response.
- OFFER→FETCH: on acceptance when more work remains.
- OFFER→SUSP: on acceptance when the advanced pointer equals the tail.

Top module: `desc_ring_walker`

## Requirements
- R1: After reset the engine is idle. `desc_valid`, `mem_req_valid`, `suspended` and `susp_pulse` are low, and every register reads zero.
- R2: Register select codes are fixed. 0 is the ring start address, 1 is the ring length (entry count minus one, LEN_W bits), 2 is the tail address, and 3 is the current descriptor address, which is read-only and ignores writes. Bits [3:0] of the start and tail addresses always read as zero.
- R3: A fetch issues four reads, in order, at current+0, +4, +8 and +12. The descriptor output carries the word from +0 in bits [31:0] up to the word from +12 in bits [127:96], and `desc_addr` equals the current pointer.
- R4: While `desc_valid` is high and `desc_ready` is low, the descriptor and its address hold steady. The current pointer changes only on an accepted descriptor or on a register write.
- R5: Accepting the descriptor at start + length*16 sets the current pointer back to the start address. Any other acceptance adds 16.
- R6: When the pointer after an acceptance equals the tail, the engine stops and `suspended` goes high. `susp_pulse` is high for exactly that first suspended cycle.
- R7: A tail write that leaves current ≠ tail restarts fetching from the idle or suspended state. A tail write equal to the current pointer leaves the engine parked with no new pulse.
- R8: Writing the start address while idle or suspended reloads the current pointer with it. While fetching or offering, such a write changes only the wrap target and leaves the current pointer unchanged.
- R9: No memory request and no descriptor is issued while idle or suspended.
- R10: A request held off by a low `mem_req_ready` stays valid with the same address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select for writes |
| reg_wr_data | input | ADDR_W | Register write value |
| reg_rd_sel | input | 2 | Register select for reads |
| reg_rd_data | output | ADDR_W | Combinational register read value |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid (in request order) |
| mem_rsp_data | input | 32 | Read data word |
| desc_valid | output | 1 | Assembled descriptor valid |
| desc_ready | input | 1 | Consumer takes the descriptor |
| desc_addr | output | ADDR_W | Address of the presented descriptor |
| desc_data | output | 128 | Four descriptor words, first word lowest |
| suspended | output | 1 | Level: ring drained, engine parked |
| susp_pulse | output | 1 | One-cycle pulse on entering suspend |

## Verification
The checker watches several rules on every cycle:
- Request addresses stay inside the current descriptor and word-aligned.
- Requests and offered descriptors hold while stalled.
- The current pointer moves only on acceptance or register writes.
- The suspend pulse lasts one cycle and coincides with the suspended level.
- The block stays silent while parked.

Other behaviour only the directed scenarios can show:
- The exact descriptor contents.
- The wrap from the last entry back to the start.
- Suspend when the tail lies behind the current pointer.
- Reload of the pointer from a start-address write while parked, and its absence while running.
- An equal-value tail write leaving the engine parked.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);
    localparam int DESC_SHIFT = $clog2(DESC_BYTES);
    localparam int DESC_W     = WORD_W * DESC_WORDS;
    localparam int CNT_W      = $clog2(DESC_WORDS + 1);

    localparam logic [1:0] SEL_BASE = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_TAIL = 2'd2;
    localparam logic [1:0] SEL_CUR  = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_OFFER = 2'd2,
        ST_SUSP  = 2'd3
    } walk_state_e;

endpackage

// File: rtl/ring_walk_regs.sv
module ring_walk_regs
    import ring_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [ADDR_W-1:0] rd_data,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] base_q,
    output logic [LEN_W-1:0]  len_q,
    output logic [ADDR_W-1:0] tail_q,
    output logic [ADDR_W-1:0] tail_eff,
    output logic              base_wr,
    output logic              kick
);

    localparam int HI = ADDR_W - DESC_SHIFT;

    logic [HI-1:0] base_hi;
    logic [HI-1:0] tail_hi;
    logic          tail_wr;

    assign base_wr = wr_en && (wr_sel == SEL_BASE);
    assign tail_wr = wr_en && (wr_sel == SEL_TAIL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            tail_hi <= '0;
            len_q   <= '0;
            kick    <= 1'b0;
        end else begin
            if (base_wr) begin
                base_hi <= wr_data[ADDR_W-1:DESC_SHIFT];
            end
            if (tail_wr) begin
                tail_hi <= wr_data[ADDR_W-1:DESC_SHIFT];
            end
            if (wr_en && (wr_sel == SEL_LEN)) begin
                len_q <= wr_data[LEN_W-1:0];
            end
            kick <= tail_wr;
        end
    end

    assign base_q   = {base_hi, {DESC_SHIFT{1'b0}}};
    assign tail_q   = {tail_hi, {DESC_SHIFT{1'b0}}};
    assign tail_eff = tail_wr ? {wr_data[ADDR_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}} : tail_q;

    always_comb begin
        unique case (rd_sel)
            SEL_BASE: rd_data = base_q;
            SEL_LEN:  rd_data = {{(ADDR_W-LEN_W){1'b0}}, len_q};
            SEL_TAIL: rd_data = tail_q;
            default:  rd_data = cur_addr;
        endcase
    end

endmodule

// File: rtl/ring_walk_ptr.sv
module ring_walk_ptr
    import ring_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [LEN_W-1:0]  len_q,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] next_addr
);

    localparam int PAD = ADDR_W - LEN_W - DESC_SHIFT;

    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] cur_q;

    assign last_addr = base_q + {{PAD{1'b0}}, len_q, {DESC_SHIFT{1'b0}}};
    assign next_addr = (cur_q == last_addr) ? base_q : cur_q + ADDR_W'(DESC_BYTES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else if (load) begin
            cur_q <= {load_addr[ADDR_W-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
        end else if (advance) begin
            cur_q <= next_addr;
        end
    end

    assign cur_addr = cur_q;

endmodule

// File: rtl/ring_walk_fsm.sv
module ring_walk_fsm
    import ring_walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] next_addr,
    input  logic [ADDR_W-1:0] tail_q,
    input  logic [ADDR_W-1:0] tail_eff,
    input  logic              kick,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    input  logic              desc_ready,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              desc_valid,
    output logic [DESC_W-1:0] desc_data,
    output logic              advance,
    output logic              parked,
    output logic              suspended,
    output logic              susp_pulse
);

    walk_state_e state_q, state_d;
    logic [CNT_W-1:0]  iss_cnt;
    logic [CNT_W-1:0]  rcv_cnt;
    logic [WORD_W-1:0] word_q [DESC_WORDS];
    logic              pulse_q;
    logic              last_rsp;

    assign last_rsp = mem_rsp_valid && (rcv_cnt == CNT_W'(DESC_WORDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_SUSP: begin
                if (kick && (cur_addr != tail_q)) begin
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (last_rsp) begin
                    state_d = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (desc_ready) begin
                    state_d = (next_addr == tail_eff) ? ST_SUSP : ST_FETCH;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req_valid = (state_q == ST_FETCH) && (iss_cnt < CNT_W'(DESC_WORDS));
        mem_req_addr  = cur_addr + {{(ADDR_W-CNT_W-2){1'b0}}, iss_cnt, 2'b00};
        desc_valid    = (state_q == ST_OFFER);
        advance       = (state_q == ST_OFFER) && desc_ready;
        parked        = (state_q == ST_IDLE) || (state_q == ST_SUSP);
        suspended     = (state_q == ST_SUSP);
        susp_pulse    = pulse_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_cnt <= '0;
            rcv_cnt <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= (state_q == ST_OFFER) && (state_d == ST_SUSP);
            if (state_q != ST_FETCH) begin
                iss_cnt <= '0;
                rcv_cnt <= '0;
            end else begin
                if (mem_req_valid && mem_req_ready) begin
                    iss_cnt <= iss_cnt + 1'b1;
                end
                if (mem_rsp_valid) begin
                    rcv_cnt <= rcv_cnt + 1'b1;
                end
            end
        end
    end

    for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[gi] <= '0;
            end else if ((state_q == ST_FETCH) && mem_rsp_valid && (rcv_cnt == CNT_W'(gi))) begin
                word_q[gi] <= mem_rsp_data;
            end
        end
        assign desc_data[gi*WORD_W +: WORD_W] = word_q[gi];
    end

endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker
    import ring_walk_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_wr_sel,
    input  logic [ADDR_W-1:0] reg_wr_data,
    input  logic [1:0]        reg_rd_sel,
    output logic [ADDR_W-1:0] reg_rd_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              desc_valid,
    input  logic              desc_ready,
    output logic [ADDR_W-1:0] desc_addr,
    output logic [DESC_W-1:0] desc_data,
    output logic              suspended,
    output logic              susp_pulse
);

    logic [ADDR_W-1:0] base_q, tail_q, tail_eff, cur_addr, next_addr;
    logic [LEN_W-1:0]  len_q;
    logic              base_wr, kick, advance, parked;

    ring_walk_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_sel   (reg_wr_sel),
        .wr_data  (reg_wr_data),
        .rd_sel   (reg_rd_sel),
        .rd_data  (reg_rd_data),
        .cur_addr (cur_addr),
        .base_q   (base_q),
        .len_q    (len_q),
        .tail_q   (tail_q),
        .tail_eff (tail_eff),
        .base_wr  (base_wr),
        .kick     (kick)
    );

    ring_walk_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_q    (base_q),
        .len_q     (len_q),
        .load      (base_wr && parked),
        .load_addr (reg_wr_data),
        .advance   (advance),
        .cur_addr  (cur_addr),
        .next_addr (next_addr)
    );

    ring_walk_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cur_addr      (cur_addr),
        .next_addr     (next_addr),
        .tail_q        (tail_q),
        .tail_eff      (tail_eff),
        .kick          (kick),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .desc_ready    (desc_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .desc_valid    (desc_valid),
        .desc_data     (desc_data),
        .advance       (advance),
        .parked        (parked),
        .suspended     (suspended),
        .susp_pulse    (susp_pulse)
    );

    assign desc_addr = cur_addr;

endmodule

// File: rtl/ring_walk_checker.sv
module ring_walk_checker
    import ring_walk_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              desc_valid,
    input logic              desc_ready,
    input logic [ADDR_W-1:0] desc_addr,
    input logic [DESC_W-1:0] desc_data,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              suspended,
    input logic              susp_pulse
);

    AST_REQ_IN_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ADDR_W-1:DESC_SHIFT] == cur_addr[ADDR_W-1:DESC_SHIFT]) && (mem_req_addr[1:0] == 2'b00)); // R3

    AST_DESC_AT_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> (desc_addr == cur_addr)); // R3

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_data) && $stable(desc_addr))); // R4

    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(desc_valid && desc_ready) && !reg_wr_en) |=> $stable(cur_addr)); // R4

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |=> !susp_pulse); // R6

    AST_PULSE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> suspended); // R6

    AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |-> (!mem_req_valid && !desc_valid)); // R9

endmodule

bind desc_ring_walker ring_walk_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr_en     (reg_wr_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .desc_valid    (desc_valid),
    .desc_ready    (desc_ready),
    .desc_addr     (desc_addr),
    .desc_data     (desc_data),
    .cur_addr      (cur_addr),
    .suspended     (suspended),
    .susp_pulse    (susp_pulse)
);

// File: tb/desc_ring_walker_test.sv
module desc_ring_walker_test;
    import ring_walk_pkg::*;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr_en = 1'b0;
    logic [1:0]    reg_wr_sel = '0;
    logic [AW-1:0] reg_wr_data = '0;
    logic [1:0]    reg_rd_sel = '0;
    logic [AW-1:0] reg_rd_data;
    logic          mem_req_valid, mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [31:0]   mem_rsp_data = '0;
    logic          desc_valid;
    logic          desc_ready = 1'b0;
    logic [AW-1:0] desc_addr;
    logic [127:0]  desc_data;
    logic          suspended, susp_pulse;

    logic stall_en = 1'b0;
    logic tog = 1'b0;
    int   req_count = 0;
    int   pulse_cnt = 0;
    int   checks = 0;
    int   fails = 0;

    always #2.5 clk = ~clk;

    desc_ring_walker uut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data),
        .reg_rd_sel(reg_rd_sel), .reg_rd_data(reg_rd_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr), .desc_data(desc_data),
        .suspended(suspended), .susp_pulse(susp_pulse)
    );

    function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
        return {a[15:0] ^ 16'hC35A, a[15:0]};
    endfunction

    function automatic logic [127:0] exp_desc(input logic [AW-1:0] a);
        return {mem_word(a + 12), mem_word(a + 8), mem_word(a + 4), mem_word(a)};
    endfunction

    assign mem_req_ready = stall_en ? tog : 1'b1;

    // memory model: in-order, one-cycle latency
    always @(posedge clk) begin
        tog           <= ~tog;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= mem_word(mem_req_addr);
        if (mem_req_valid && mem_req_ready) req_count <= req_count + 1;
        if (rst_n && susp_pulse) pulse_cnt <= pulse_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [AW-1:0] val);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = val;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] sel, output logic [AW-1:0] val);
        @(negedge clk);
        reg_rd_sel = sel;
        #1 val = reg_rd_data;
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 300 && !desc_valid; k++) @(negedge clk);
    endtask

    task automatic take_desc(input logic [AW-1:0] a, input int hold, input string tag);
        wait_valid();
        check(desc_valid, {tag, " desc_valid"}, 128'(desc_valid), 128'(1));
        check(desc_addr == a, {tag, " desc_addr"}, 128'(desc_addr), 128'(a));
        check(desc_data == exp_desc(a), {tag, " desc_data"}, desc_data, exp_desc(a));
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            check(desc_valid && desc_data == exp_desc(a) && desc_addr == a,
                  {tag, " R4 hold"}, desc_data, exp_desc(a));
        end
        desc_ready = 1'b1;
        @(negedge clk);
        desc_ready = 1'b0;
    endtask

    task automatic wait_susp();
        for (int k = 0; k < 300 && !suspended; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        check(!desc_valid && !mem_req_valid && !suspended && !susp_pulse, "R1 outputs idle",
              128'({desc_valid, mem_req_valid, suspended, susp_pulse}), 128'(0));
        for (int s = 0; s < 4; s++) begin
            rd_reg(2'(s), v);
            check(v == '0, "R1 register reads zero", 128'(v), 128'(0));
        end
    endtask

    task automatic t_first_run();
        logic [AW-1:0] v;
        wr_reg(SEL_BASE, 32'h1000);
        rd_reg(SEL_CUR, v);
        check(v == 32'h1000, "R8 idle base load", 128'(v), 128'h1000);
        wr_reg(SEL_LEN, 32'd3);
        rd_reg(SEL_LEN, v);
        check(v == 32'd3, "R2 length readback", 128'(v), 128'd3);
        wr_reg(SEL_TAIL, 32'h1020);
        take_desc(32'h1000, 0, "R3 first");
        take_desc(32'h1010, 0, "R3 second");
        wait_susp();
        check(suspended, "R6 suspended", 128'(suspended), 128'(1));
        @(negedge clk);
        check(pulse_cnt == 1, "R6 one pulse", 128'(pulse_cnt), 128'(1));
        check(req_count == 8, "R3 eight reads", 128'(req_count), 128'(8));
        rd_reg(SEL_CUR, v);
        check(v == 32'h1020, "R6 cur at tail", 128'(v), 128'h1020);
    endtask

    task automatic t_wrap();
        logic [AW-1:0] v;
        wr_reg(SEL_TAIL, 32'h1000);
        take_desc(32'h1020, 0, "R7 resume");
        take_desc(32'h1030, 0, "R5 last entry");
        wait_susp();
        @(negedge clk);
        rd_reg(SEL_CUR, v);
        check(v == 32'h1000, "R5 wrap to base", 128'(v), 128'h1000);
        check(pulse_cnt == 2, "R6 pulse after wrap", 128'(pulse_cnt), 128'(2));
    endtask

    task automatic t_running();
        logic [AW-1:0] v;
        stall_en = 1'b1;
        wr_reg(SEL_TAIL, 32'h1020);
        wait_valid();
        wr_reg(SEL_BASE, 32'h3000);
        rd_reg(SEL_CUR, v);
        check(v == 32'h1000, "R8 base write while running", 128'(v), 128'h1000);
        wr_reg(SEL_BASE, 32'h1000);
        take_desc(32'h1000, 5, "R4 backpressure");
        take_desc(32'h1010, 0, "R10 stalled memory");
        stall_en = 1'b0;
        wait_susp();
        @(negedge clk);
        check(pulse_cnt == 3, "R6 pulse third", 128'(pulse_cnt), 128'(3));
    endtask

    task automatic t_parked();
        logic [AW-1:0] v;
        int rc, pc;
        wr_reg(SEL_BASE, 32'h4008);
        rd_reg(SEL_BASE, v);
        check(v == 32'h4000, "R2 base low bits zero", 128'(v), 128'h4000);
        rd_reg(SEL_CUR, v);
        check(v == 32'h4000, "R8 suspended base reload", 128'(v), 128'h4000);
        wr_reg(SEL_LEN, 32'd1);
        wr_reg(SEL_CUR, 32'h5550);
        rd_reg(SEL_CUR, v);
        check(v == 32'h4000, "R2 current read-only", 128'(v), 128'h4000);
        rc = req_count; pc = pulse_cnt;
        wr_reg(SEL_TAIL, 32'h400C);
        rd_reg(SEL_TAIL, v);
        check(v == 32'h4000, "R2 tail low bits zero", 128'(v), 128'h4000);
        repeat (20) @(negedge clk);
        check(suspended, "R7 equal tail stays parked", 128'(suspended), 128'(1));
        check(req_count == rc, "R9 no reads while parked", 128'(req_count), 128'(rc));
        check(pulse_cnt == pc, "R7 no new pulse", 128'(pulse_cnt), 128'(pc));
        wr_reg(SEL_TAIL, 32'h4010);
        take_desc(32'h4000, 0, "R7 restart");
        wait_susp();
        wr_reg(SEL_TAIL, 32'h4000);
        take_desc(32'h4010, 0, "R5 short ring last");
        wait_susp();
        @(negedge clk);
        rd_reg(SEL_CUR, v);
        check(v == 32'h4000, "R5 short ring wrap", 128'(v), 128'h4000);
        check(suspended && pulse_cnt == pc + 2, "R6 short ring pulses", 128'(pulse_cnt), 128'(pc + 2));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_first_run();
                t_wrap();
                t_running();
                t_parked();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule